// File: doc/BRIEF.md
# Edge-Detecting GPIO Port

A 32-line general-purpose I/O port with a small 32-bit register interface. Each line can be an input or an output. Output lines are driven from a data latch. Input lines pass through a per-line buffer enable and then a two-flop synchroniser. The data register reads back the latched value for outputs and the pin value for inputs.

Every synchronised input line is watched for edges. A per-line control bit selects either falling-edge-only detection or detection of both edges. A detected edge sets a sticky event bit, and software clears that bit by writing a one to it. A single interrupt output is raised while any event bit is set on a line whose mask bit is 1.

Register bits run in reverse line order: line n sits at bit 31−n of every per-line register. The pin-side vectors use natural order, so `gpio_in_i[n]` is line n.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Line n occupies bit (31−n) of every per-line register, while pin vectors `gpio_in_i`, `gpio_out_o` and `gpio_oe_o` carry line n at index n.
- R2: A direction bit (offset 0x00) of 1 makes the line an output: `gpio_oe_o` is 1 for that line, and `gpio_out_o` carries the data latch (offset 0x08). A direction bit of 0 makes the line an input.
- R3: An input line whose input-buffer-enable bit (offset 0x1C) is 0 reads as 0 in the data register, whatever the pin level.
- R4: A data-register read returns the latch bit for output lines and the synchronised, buffer-gated pin value for input lines, selected per bit by the direction register.
- R5: An edge-control bit (offset 0x14) of 1 detects only falling edges on that line. A bit of 0 detects both rising and falling edges.
- R6: A detected edge on a line whose buffer-enable bit is 1 sets that line's bit in the event register (offset 0x0C), whatever its mask bit. A line with its buffer disabled sets no event.
- R7: Writing to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every event.
- R8: If an edge is detected in the same cycle that software writes a 1 to clear that event bit, the bit stays set.
- R9: `irq_o` is high exactly when some bit of (event AND mask) is 1, with the mask at offset 0x10. Writing 0 to the mask drops `irq_o` in the next cycle.
- R10: After reset every register is zero, `gpio_oe_o` is all zero and `irq_o` is low.
- R11: Offset 0x04 is reserved, so writes to it are ignored and reads return 0. Any unmapped offset reads 0. Read data appears on `rdata_o` one cycle after the `rd_en_i` strobe and holds until the next read.
- R12: A pin change is seen by the synchroniser and sets its event bit on the third rising clock edge after the change, and `irq_o` follows combinationally from the event and mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe; data registered on the next edge |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| gpio_in_i | input | 32 | Pin levels, line n at index n |
| gpio_out_o | output | 32 | Output latch, line n at index n |
| gpio_oe_o | output | 32 | Output enable (direction), line n at index n |
| irq_o | output | 1 | Combined interrupt |

## Verification
A register write takes effect on the edge where the strobe is sampled, so the pin outputs and `irq_o` are checked on the falling edge after it. Read data is due one edge after the read strobe and is captured on the falling edge that follows. Pin stimulus reaches the event register three rising edges after a falling-edge change. The latency test therefore samples `irq_o` on the second falling edge, expecting it low, and on the third, expecting it high. The clear-versus-edge race puts the clear strobe on exactly the third edge. The other edge tests wait at least four cycles before reading.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int NLINES = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_OD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_EVT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSK = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ECT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_IBE = 5'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,    // synchronised, register bit order
  input  logic [W-1:0] ibe_i,
  input  logic [W-1:0] fall_only_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, evt_q;

  for (genvar b = 0; b < W; b++) begin : g_line
    logic rise, fall;
    assign rise     = pin_i[b] & ~prev_q[b];
    assign fall     = ~pin_i[b] & prev_q[b];
    assign hit_o[b] = ibe_i[b] & (fall | (rise & ~fall_only_i[b]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= pin_i;
      // new edge wins over a simultaneous clear
      evt_q  <= (evt_q & ~clr_i) | hit_o;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int N           = NLINES,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      gpio_in_i,
  output logic [N-1:0]      gpio_out_o,
  output logic [N-1:0]      gpio_oe_o,
  output logic              irq_o
);
  logic [N-1:0] dir_q, dat_q, msk_q, ect_q, ibe_q;
  logic [N-1:0] pin_sync, pin_reg, pin_gated;
  logic [N-1:0] evt_q, hit, clr;
  logic [N-1:0] rd_mux, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ect_q <= '0;
      ibe_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFF_DIR: dir_q <= wdata_i;
        OFF_DAT: dat_q <= wdata_i;
        OFF_MSK: msk_q <= wdata_i;
        OFF_ECT: ect_q <= wdata_i;
        OFF_IBE: ibe_q <= wdata_i;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_in_i),
    .q_o   (pin_sync)
  );

  // pin index n <-> register bit N-1-n
  for (genvar n = 0; n < N; n++) begin : g_map
    assign pin_reg[N-1-n] = pin_sync[n];
    assign gpio_out_o[n]  = dat_q[N-1-n];
    assign gpio_oe_o[n]   = dir_q[N-1-n];
  end

  assign pin_gated = pin_reg & ibe_q;
  assign clr       = (wr_en_i && addr_i == OFF_EVT) ? wdata_i : '0;

  gpio_evt #(.W(N)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_reg),
    .ibe_i      (ibe_q),
    .fall_only_i(ect_q),
    .clr_i      (clr),
    .hit_o      (hit),
    .evt_o      (evt_q)
  );

  always_comb begin
    unique case (addr_i)
      OFF_DIR: rd_mux = dir_q;
      OFF_DAT: rd_mux = (dat_q & dir_q) | (pin_gated & ~dir_q);
      OFF_EVT: rd_mux = evt_q;
      OFF_MSK: rd_mux = msk_q;
      OFF_ECT: rd_mux = ect_q;
      OFF_IBE: rd_mux = ibe_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(evt_q & msk_q);
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
#(
  parameter int N = NLINES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      rdata_o,
  input logic [N-1:0]      gpio_oe_o,
  input logic              irq_o,
  input logic [N-1:0]      evt_q,
  input logic [N-1:0]      hit
);
  // R1
  dir_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIR) |=> gpio_oe_o[0] == $past(wdata_i[N-1]));

  // R7
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFF_EVT) |=> (evt_q & $past(evt_q)) == $past(evt_q));

  // R7
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EVT && wdata_i == '1 && hit == '0) |=> evt_q == '0);

  // R8
  race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> (evt_q & $past(hit)) == $past(hit));

  // R9
  mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MSK && wdata_i == '0) |=> !irq_o);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_q != '0);

  // R11
  rsvd_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_OD) |=> rdata_o == '0);
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.N(N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .gpio_oe_o(gpio_oe_o),
  .irq_o    (irq_o),
  .evt_q    (evt_q),
  .hit      (hit)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  import gpio_edge_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, rdata, gpio_in = '0, gpio_out, gpio_oe;
  logic              irq;
  int                total = 0, bad = 0;
  logic [31:0]       rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .gpio_in_i(gpio_in),
    .gpio_out_o(gpio_out), .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 oe", gpio_oe, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h0);
    bus_rd(OFF_DIR, rv); check("R10 dir", rv, 32'h0);
    bus_rd(OFF_DAT, rv); check("R10 dat", rv, 32'h0);
    bus_rd(OFF_EVT, rv); check("R10 evt", rv, 32'h0);
    bus_rd(OFF_MSK, rv); check("R10 msk", rv, 32'h0);
    bus_rd(OFF_IBE, rv); check("R10 ibe", rv, 32'h0);
  endtask

  task automatic t_output;
    bus_wr(OFF_DIR, 32'hC000_0000);
    check("R1 R2 oe lines 0,1", gpio_oe, 32'h0000_0003);
    bus_wr(OFF_DAT, 32'h4000_0000);
    check("R1 R2 out line 1", gpio_out, 32'h0000_0002);
    bus_rd(OFF_DIR, rv); check("R11 dir readback", rv, 32'hC000_0000);
  endtask

  task automatic t_readback;
    bus_wr(OFF_IBE, 32'hFFFF_FFFF);
    @(negedge clk); gpio_in = 32'h0000_0F01;
    settle(4);
    bus_rd(OFF_DAT, rv); check("R4 merged read", rv, 32'h40F0_0000);
    bus_wr(OFF_IBE, 32'hFF3F_FFFF);
    bus_rd(OFF_DAT, rv); check("R3 ibe gating", rv, 32'h4030_0000);
    gpio_in = 32'h0;
    settle(4);
  endtask

  task automatic t_reserved;
    bus_wr(OFF_OD, 32'hFFFF_FFFF);
    bus_rd(OFF_OD, rv); check("R11 reserved reads 0", rv, 32'h0);
    bus_rd(5'h18, rv);  check("R11 unmapped reads 0", rv, 32'h0);
    bus_rd(OFF_DIR, rv); check("R11 reserved write ignored", rv, 32'hC000_0000);
  endtask

  task automatic t_edges;
    bus_wr(OFF_EVT, 32'hFFFF_FFFF);
    bus_rd(OFF_EVT, rv); check("R7 clear all", rv, 32'h0);
    bus_wr(OFF_ECT, 32'h0800_0000);   // line 4 falling only, line 5 both
    @(negedge clk); gpio_in = 32'h0000_0030;
    settle(4);
    bus_rd(OFF_EVT, rv); check("R5 rising only on both-edge line", rv, 32'h0400_0000);
    bus_wr(OFF_EVT, 32'hFFFF_FFFF);
    @(negedge clk); gpio_in = 32'h0;
    settle(4);
    bus_rd(OFF_EVT, rv); check("R5 falling on both lines", rv, 32'h0C00_0000);
    bus_wr(OFF_EVT, 32'h0400_0000);
    bus_rd(OFF_EVT, rv); check("R7 write one clears, zero keeps", rv, 32'h0800_0000);
  endtask

  task automatic t_irq;
    check("R6 masked event latched, irq low", {31'h0, irq}, 32'h0);
    bus_wr(OFF_MSK, 32'h0800_0000);
    check("R9 irq on unmask", {31'h0, irq}, 32'h1);
    bus_wr(OFF_MSK, 32'h0);
    check("R9 irq off on mask 0", {31'h0, irq}, 32'h0);
    bus_wr(OFF_EVT, 32'hFFFF_FFFF);
    @(negedge clk); gpio_in = 32'h0000_0100;  // line 8, buffer disabled
    settle(4);
    bus_rd(OFF_EVT, rv); check("R6 disabled buffer sets no event", rv, 32'h0);
    gpio_in = 32'h0;
    settle(4);
  endtask

  task automatic t_latency;
    bus_wr(OFF_MSK, 32'h0400_0000);
    bus_wr(OFF_EVT, 32'hFFFF_FFFF);
    @(negedge clk); gpio_in = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk); check("R12 irq low after 2 edges", {31'h0, irq}, 32'h0);
    @(negedge clk); check("R12 irq high after 3 edges", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_race;
    bus_wr(OFF_EVT, 32'hFFFF_FFFF);
    check("R7 irq cleared", {31'h0, irq}, 32'h0);
    @(negedge clk); gpio_in = 32'h0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = OFF_EVT; wdata = 32'hFFFF_FFFF;
    @(negedge clk); wr_en = 1'b0;
    bus_rd(OFF_EVT, rv); check("R8 edge wins over clear", rv, 32'h0400_0000);
    check("R8 irq stays", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_output();
    t_readback();
    t_reserved();
    t_edges();
    t_irq();
    t_latency();
    t_race();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule